// File: doc/BRIEF.md
# Dual-Format MDIO Management Master

This block drives the two-wire management bus of external PHY devices. A host first loads a 16-bit write-data register. It then presents one command word and sets the go bit. The command word holds a start code, an opcode, a 5-bit PHY address, a 5-bit register-or-device field and a 16-bit address word. The engine serializes one 64-bit frame on MDIO, clocked by a divided MDC. For reads it releases the line, samples the PHY's reply and places it in a read-data register.

The start-code value picks the frame flavour. The value 1 produces a Clause 22 frame, in which the 5-bit field carries the register number. The value 0 produces a Clause 45 frame, in which that field carries the device number. A Clause 45 register access is two calls: an address frame that carries the register address from the command word, then a read or write frame to the same PHY and device. While a frame is in flight the busy output is high and further commands are dropped. The host polls busy to learn when the frame has finished.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy is 0, MDC is 1, mdio_oe is 0, mdio_o is 1 and rd_data is 0. MDC stays high and mdio_oe stays low whenever busy is 0.
- R2: A frame goes out MSB first, one bit per MDC period, in this order: 32 ones, cmd_st (2 bits, 01 for Clause 22, 00 for Clause 45), cmd_op (2 bits), cmd_phy (5 bits), cmd_reg (5 bits), a 2-bit turnaround, then 16 data bits.
- R3: The opcode is sent as given. An opcode with bit 1 set is a read: value 2 in Clause 22, and values 2 (read with address increment) and 3 in Clause 45. Opcodes 0 (Clause 45 address) and 1 (write) drive the whole frame.
- R4: On a driven frame the turnaround is sent as 1 then 0. When cmd_st is 0 and cmd_op is 0, the data bits are cmd_addr. Otherwise they are the write-data register, which holds the last value written with wdata_we in an earlier cycle.
- R5: On a read, mdio_oe is 0 from the first turnaround bit to the end of the frame. The 16 bits present on mdio_i at the MDC rising edges of the data phase, MSB first, appear on rd_data in the cycle busy falls. Other frames leave rd_data unchanged.
- R6: A launch (cmd_we and cmd_go with busy low) sets busy and pulls MDC low at the same clock edge. Busy falls exactly 128·H clock cycles later, with MDC high.
- R7: A command presented while busy is 1 is ignored: the frame in flight is unchanged and no further frame starts.
- R8: MDC low and high phases each last H = max(mdc_half, 1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc_half | input | DIV_W | MDC half-period in clock cycles (0 acts as 1) |
| wdata_we | input | 1 | Load the write-data register |
| wdata | input | 16 | Write data |
| cmd_we | input | 1 | Command write strobe |
| cmd_go | input | 1 | Start bit accompanying a command write |
| cmd_st | input | 2 | Start code: 1 Clause 22, 0 Clause 45 |
| cmd_op | input | 2 | Opcode |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register number (Clause 22) or device number (Clause 45) |
| cmd_addr | input | 16 | Register address for Clause 45 address frames |
| busy | output | 1 | Start bit, held high until the frame finishes |
| rd_data | output | 16 | Last read result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
With a half-period H, busy is due to fall exactly 128·H cycles after the launch edge, and rd_data is due in that same cycle. The bench counts falling clock edges with busy high and compares the count, the idle MDC level and rd_data at the first falling edge after busy drops. Wire bits are due at each MDC rise, so the monitor samples MDIO on the falling clock edge that first shows MDC high. The PHY model changes mdio_i on the falling clock edge that first shows MDC low, half a period before the engine samples it. Each frame gathered by the monitor is compared with the next expected frame that the driver queued.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] mdc_half,
  input  logic             wdata_we,
  input  logic [15:0]      wdata,
  input  logic             cmd_we,
  input  logic             cmd_go,
  input  logic [1:0]       cmd_st,
  input  logic [1:0]       cmd_op,
  input  logic [4:0]       cmd_phy,
  input  logic [4:0]       cmd_reg,
  input  logic [15:0]      cmd_addr,
  output logic             busy,
  output logic [15:0]      rd_data,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  localparam int FRAME_BITS = 64;
  localparam int BW         = $clog2(FRAME_BITS);
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;

  logic             busy_q, mdc_q, rd_q;
  logic [DIV_W-1:0] cnt_q;
  logic [BW-1:0]    bit_q;
  logic [63:0]      sh_q;
  logic [15:0]      wd_q, rx_q, rd_data_q;

  wire [DIV_W-1:0] half_m1   = (mdc_half == '0) ? '0 : mdc_half - 1'b1;
  wire             launch    = cmd_we & cmd_go & ~busy_q;
  wire             phase_end = busy_q & (cnt_q >= half_m1);
  wire             last_bit  = (bit_q == BW'(FRAME_BITS - 1));
  wire             in_data   = (32'(bit_q) >= DATA_POS);
  wire             released  = rd_q & (32'(bit_q) >= TA_POS);
  wire [15:0]      tx_data   = (cmd_st == 2'd0 && cmd_op == 2'd0) ? cmd_addr : wd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      mdc_q     <= 1'b1;
      rd_q      <= 1'b0;
      cnt_q     <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      wd_q      <= '0;
      rx_q      <= '0;
      rd_data_q <= '0;
    end else begin
      if (wdata_we) wd_q <= wdata;
      if (launch) begin
        busy_q <= 1'b1;
        mdc_q  <= 1'b0;
        cnt_q  <= '0;
        bit_q  <= '0;
        rd_q   <= cmd_op[1];
        sh_q   <= {32'hFFFF_FFFF, cmd_st, cmd_op, cmd_phy, cmd_reg, 2'b10, tx_data};
      end else if (busy_q) begin
        if (phase_end) begin
          cnt_q <= '0;
          if (!mdc_q) begin
            mdc_q <= 1'b1;
            if (rd_q && in_data) rx_q <= {rx_q[14:0], mdio_i};
          end else if (last_bit) begin
            busy_q <= 1'b0;
            if (rd_q) rd_data_q <= rx_q;
          end else begin
            mdc_q <= 1'b0;
            bit_q <= bit_q + 1'b1;
            sh_q  <= {sh_q[62:0], 1'b1};
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign rd_data = rd_data_q;
  assign mdc     = mdc_q;
  assign mdio_o  = busy_q ? sh_q[63] : 1'b1;
  assign mdio_oe = busy_q & ~released;
endmodule

module mdio_master_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] mdc_half,
  input logic             busy,
  input logic             mdc,
  input logic             mdio_oe
);
  logic             mdc_d;
  logic [DIV_W-1:0] ph;
  wire  [DIV_W-1:0] h_m1 = (mdc_half == '0) ? '0 : mdc_half - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_d <= 1'b1;
      ph    <= '0;
    end else begin
      mdc_d <= mdc;
      ph    <= (mdc != mdc_d) ? '0 : ph + 1'b1;
    end
  end

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mdc && !mdio_oe));

  assert_start_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !mdc);

  assert_release_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mdio_oe) |=> !mdio_oe);

  assert_phase_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mdc != mdc_d)) |-> (ph == h_m1));
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mdc_half(mdc_half),
  .busy(busy), .mdc(mdc), .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 8;

  logic             clk = 1'b0, rst_n = 1'b0;
  logic [DIV_W-1:0] mdc_half = 8'd2;
  logic             wdata_we = 1'b0, cmd_we = 1'b0, cmd_go = 1'b0;
  logic [15:0]      wdata = '0, cmd_addr = '0;
  logic [1:0]       cmd_st = '0, cmd_op = '0;
  logic [4:0]       cmd_phy = '0, cmd_reg = '0;
  logic             busy, mdc, mdio_o, mdio_oe;
  logic             mdio_i = 1'b1;
  logic [15:0]      rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mdc_half(mdc_half),
    .wdata_we(wdata_we), .wdata(wdata),
    .cmd_we(cmd_we), .cmd_go(cmd_go), .cmd_st(cmd_st), .cmd_op(cmd_op),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_addr(cmd_addr),
    .busy(busy), .rd_data(rd_data), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_chk = 0, n_fail = 0, frames_seen = 0, rises = 0;
  bit finished = 0;
  logic [127:0] expq[$];
  logic [15:0]  phy_resp = '0;
  logic         mdc_prev = 1'b1;
  logic [63:0]  obs_v = '0, obs_oe = '0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor and PHY model
  always @(negedge clk) begin
    if (!busy) rises = 0;
    if (busy && mdc && !mdc_prev) begin
      obs_v  = {obs_v[62:0], mdio_oe ? mdio_o : 1'b0};
      obs_oe = {obs_oe[62:0], mdio_oe};
      rises++;
      if (rises == 64) begin
        frames_seen++;
        if (expq.size() == 0) chk(0, "R7 unexpected frame", {obs_v, obs_oe}, '0);
        else begin
          logic [127:0] e;
          e = expq.pop_front();
          chk({obs_v, obs_oe} == e, "R2 R3 R4 R5 frame content", {obs_v, obs_oe}, e);
        end
      end
    end
    if (busy && !mdc && mdc_prev) begin
      if (rises >= 48) begin
        int k;
        k = 63 - rises;
        mdio_i = phy_resp[k];
      end else mdio_i = (rises == 47) ? 1'b0 : 1'b1;
    end
    mdc_prev = mdc;
  end

  task automatic run(input logic [1:0] st, input logic [1:0] op, input logic [4:0] phy,
                     input logic [4:0] rg, input logic [15:0] addr, input logic [15:0] wd,
                     input logic [15:0] resp, input logic [7:0] h, input bit poke);
    int cyc = 0;
    int heff = (h == 0) ? 1 : int'(h);
    bit rd = op[1];
    logic [63:0] ev, eo;
    logic [15:0] rd_before = rd_data;
    mdc_half = h;
    phy_resp = resp;
    wdata = wd; wdata_we = 1'b1;
    @(negedge clk);
    wdata_we = 1'b0;
    ev = {32'hFFFF_FFFF, st, op, phy, rg, 2'b10, (st == 2'd0 && op == 2'd0) ? addr : wd};
    eo = rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
    expq.push_back({ev & eo, eo});
    cmd_st = st; cmd_op = op; cmd_phy = phy; cmd_reg = rg; cmd_addr = addr;
    cmd_we = 1'b1; cmd_go = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0; cmd_go = 1'b0;
    while (busy) begin
      cyc++;
      if (poke && cyc == 20) begin
        cmd_st = ~st; cmd_op = ~op; cmd_phy = ~phy; cmd_reg = ~rg; cmd_addr = ~addr;
        cmd_we = 1'b1; cmd_go = 1'b1;
      end else begin
        cmd_we = 1'b0; cmd_go = 1'b0;
      end
      @(negedge clk);
    end
    cmd_we = 1'b0; cmd_go = 1'b0;
    chk(cyc == 128 * heff, "R6 R8 busy length", cyc, 128 * heff);
    chk(mdc && !mdio_oe && mdio_o, "R6 idle after frame", {mdc, mdio_oe, mdio_o}, 3'b101);
    if (rd) chk(rd_data == resp, "R5 read data", rd_data, resp);
    else    chk(rd_data == rd_before, "R5 rd_data kept on non-read", rd_data, rd_before);
    if (poke) begin
      repeat (4) @(negedge clk);
      chk(!busy, "R7 command while busy ignored", busy, 0);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(!busy && mdc && !mdio_oe && mdio_o && rd_data == 16'h0, "R1 reset state",
        {busy, mdc, mdio_oe, mdio_o, rd_data}, {4'b0101, 16'h0});
    rst_n = 1'b1;
    @(negedge clk);
    run(2'd1, 2'd1, 5'h03, 5'h1A, 16'h0000, 16'hA5C3, 16'h0000, 8'd2, 0); // R2 R4 Clause 22 write
    run(2'd1, 2'd2, 5'h1F, 5'h00, 16'h0000, 16'h1111, 16'hBEEF, 8'd1, 0); // R3 R5 Clause 22 read
    run(2'd0, 2'd0, 5'h0A, 5'h1E, 16'h1234, 16'hFFFF, 16'h0000, 8'd3, 0); // R4 Clause 45 address
    run(2'd0, 2'd3, 5'h0A, 5'h1E, 16'h0000, 16'h2222, 16'h8001, 8'd0, 0); // R3 R8 half=0
    run(2'd0, 2'd1, 5'h0A, 5'h1E, 16'h9999, 16'h0F0F, 16'h0000, 8'd2, 0); // R4 Clause 45 write
    run(2'd0, 2'd2, 5'h15, 5'h07, 16'h0000, 16'h3333, 16'h5AA5, 8'd2, 1); // R3 R7 read-inc
    run(2'd1, 2'd1, 5'h00, 5'h1F, 16'h0000, 16'h7E81, 16'h0000, 8'd1, 1); // R7 Clause 22 write
    chk(frames_seen == 7 && expq.size() == 0, "R7 frame count",
        frames_seen, 7);
    chk(!busy && mdc && !mdio_oe, "R1 idle at end", {busy, mdc, mdio_oe}, 3'b010);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule